// File: doc/BRIEF.md
# Maskable-Write GPIO Bank

This block is the register file of one 32-pin general-purpose I/O bank. It keeps the values the bank drives onto its pins, a per-pin direction setting and a per-pin drive-enable setting. It also samples the pin levels through a two-flop synchronizer and offers them as a read-only word.

The output values are written through two half-word ports, one for pins 0 to 15 and one for pins 16 to 31. In each port the upper sixteen bits of the written word are an active-low mask and the lower sixteen bits are the new values. Software can therefore set or clear any group of pins in one store, with no read-modify-write and no race against other writers of the same bank.

A pin is driven only when it is set as an output and its drive enable is set. Selected pins, given by a parameter and by default pins 7 and 8, are output-only: their direction bits are held at 1.

Top module: `gpio_bank_regs`

## Requirements
- R1: A write to the low port (offset 8*BANK_IDX, default 0x000) updates pin_out[k] to wdata[k] for each k in 0..15 whose mask bit wdata[16+k] is 0. Pins 16..31 keep their values.
- R2: A write to the high port (offset 8*BANK_IDX+4, default 0x004) updates pin_out[16+k] to wdata[k] for each k in 0..15 whose mask bit wdata[16+k] is 0. Pins 0..15 keep their values.
- R3: Where a mask bit is 1, the matching pin keeps its old output value. No cycle without a write to one of the two ports changes pin_out.
- R4: A read of the data view (offset 0x060+4*BANK_IDX) returns pin_in as sampled through two flops. A change on pin_in shows up in the read word two rising edges later and not after one.
- R5: The direction register (offset 0x204+0x40*BANK_IDX, 1 = output) reads back the last value written to it, apart from the forced bits of R8.
- R6: The drive-enable register (offset 0x208+0x40*BANK_IDX) reads back the last value written to it.
- R7: pin_oe[k] is 1 only when direction bit k and drive-enable bit k are both 1.
- R8: Direction bits selected by FIXED_DIR_MASK (default bits 7 and 8) always read 1. Writes that try to clear them have no effect.
- R9: After reset, pin_out and pin_oe are 0, the drive-enable register reads 0, and the direction register reads FIXED_DIR_MASK.
- R10: Reads of the two write-only ports and of unmapped offsets return 0. Writes to the data view or to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Values to drive on the pins |
| pin_oe | output | 32 | Per-pin drive enable |

## Verification
Every pin is set and then cleared through a mask that exposes only that pin. This separates the two half ports and catches any error in bit mapping or mask polarity. A stream of pseudo-random mask and data words is then applied and compared against an arithmetic model, which catches mixed keep and update cases. A one-hot sweep of the direction register with all drive enables set shows the forced bits and the gating of pin_oe. The synchronizer is checked at one and at two edges after a pin change, so that a missing or extra stage is detected.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int          ADDR_W         = 12,
  parameter int          BANK_IDX       = 0,
  parameter logic [31:0] FIXED_DIR_MASK = 32'h0000_0180
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe
);
  localparam int HALF = 16;
  localparam logic [ADDR_W-1:0] A_VIEW = ADDR_W'(32'h060 + 4 * BANK_IDX);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(32'h204 + 32'h40 * BANK_IDX);
  localparam logic [ADDR_W-1:0] A_OEN  = ADDR_W'(32'h208 + 32'h40 * BANK_IDX);

  logic [31:0] dir_q, oen_q, sync1_q, sync2_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(8 * BANK_IDX + 4 * h);
    logic [HALF-1:0] val_q;
    logic            hit;
    logic [HALF-1:0] keep;
    assign hit  = bus_we && (bus_addr == A_PORT);
    assign keep = bus_wdata[31:16];
    always_ff @(posedge clk) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= (val_q & keep) | (bus_wdata[HALF-1:0] & ~keep);
    end
    assign pin_out[h*HALF +: HALF] = val_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= FIXED_DIR_MASK;
      oen_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_DIR) dir_q <= bus_wdata | FIXED_DIR_MASK;
      if (bus_addr == A_OEN) oen_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    case (bus_addr)
      A_VIEW:  bus_rdata = sync2_q;
      A_DIR:   bus_rdata = dir_q;
      A_OEN:   bus_rdata = oen_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_oe = dir_q & oen_q;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int          ADDR_W         = 12,
  parameter int          BANK_IDX       = 0,
  parameter logic [31:0] FIXED_DIR_MASK = 32'h0000_0180
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       pin_in,
  input logic [31:0]       pin_out,
  input logic [31:0]       pin_oe
);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(8 * BANK_IDX);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(8 * BANK_IDX + 4);
  localparam logic [ADDR_W-1:0] A_VIEW = ADDR_W'(32'h060 + 4 * BANK_IDX);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(32'h204 + 32'h40 * BANK_IDX);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)        age <= '0;
    else if (age != 3) age <= age + 2'd1;
  end

  a_r1_low_port: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LO) |=>
      pin_out[15:0] == (($past(pin_out[15:0]) & $past(bus_wdata[31:16])) |
                        ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16])))
      && $stable(pin_out[31:16]));

  a_r2_high_port: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_HI) |=>
      pin_out[31:16] == (($past(pin_out[31:16]) & $past(bus_wdata[31:16])) |
                         ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16])))
      && $stable(pin_out[15:0]));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 0 && !(bus_we && (bus_addr == A_LO || bus_addr == A_HI))) |=> $stable(pin_out));

  a_r4_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3 && bus_addr == A_VIEW) |-> bus_rdata == $past(pin_in, 2));

  a_r7_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DIR) |-> (pin_oe & ~bus_rdata) == 32'h0);

  a_r8_forced_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_DIR) |-> (bus_rdata & FIXED_DIR_MASK) == FIXED_DIR_MASK);
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .ADDR_W(ADDR_W), .BANK_IDX(BANK_IDX), .FIXED_DIR_MASK(FIXED_DIR_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
  .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;
  localparam logic [11:0] A_LO = 12'h000, A_HI = 12'h004, A_VIEW = 12'h060;
  localparam logic [11:0] A_DIR = 12'h204, A_OEN = 12'h208;
  localparam logic [31:0] FIXED = 32'h0000_0180;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  int checks = 0, errors = 0;
  logic [31:0] exp_out = '0;
  logic [31:0] rv;
  logic [31:0] lfsr = 32'h1234_5678;

  always #2.5 clk = ~clk;

  gpio_bank_regs uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w);
    return (old & w[31:16]) | (w[15:0] & ~w[31:16]);
  endfunction

  task automatic port_wr(input bit high, input logic [31:0] w);
    wr(high ? A_HI : A_LO, w);
    if (high) exp_out[31:16] = merge(exp_out[31:16], w);
    else      exp_out[15:0]  = merge(exp_out[15:0], w);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9 pin_out", pin_out, 32'h0);
    chk("R9 pin_oe", pin_oe, 32'h0);
    rd(A_DIR, rv); chk("R9 dir", rv, FIXED);
    rd(A_OEN, rv); chk("R9 oen", rv, 32'h0);

    // R1 R2: one pin at a time, set then clear
    for (int p = 0; p < 32; p++) begin
      port_wr(p >= 16, {~(16'h1 << (p % 16)), 16'hFFFF});
      chk(p >= 16 ? "R2 set" : "R1 set", pin_out, exp_out);
    end
    for (int p = 0; p < 32; p++) begin
      port_wr(p >= 16, {~(16'h1 << (p % 16)), 16'h0000});
      chk(p >= 16 ? "R2 clear" : "R1 clear", pin_out, exp_out);
    end

    // R3: full mask changes nothing
    port_wr(0, 32'h0000_A5A5); port_wr(1, 32'h0000_3C3C);
    chk("R1 R2 full write", pin_out, 32'h3C3C_A5A5);
    wr(A_LO, 32'hFFFF_5A5A); chk("R3 masked low", pin_out, 32'h3C3C_A5A5);
    wr(A_HI, 32'hFFFF_C3C3); chk("R3 masked high", pin_out, 32'h3C3C_A5A5);

    // R1 R2 R3 mixed pseudo-random words
    for (int i = 0; i < 40; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      port_wr(lfsr[0], lfsr);
      chk("R1 R2 R3 mixed", pin_out, exp_out);
    end

    // R5 R7 R8: one-hot direction with all drive enables on
    wr(A_OEN, 32'hFFFF_FFFF);
    rd(A_OEN, rv); chk("R6 oen ones", rv, 32'hFFFF_FFFF);
    for (int p = 0; p < 32; p++) begin
      wr(A_DIR, 32'h1 << p);
      rd(A_DIR, rv); chk("R5 R8 dir", rv, (32'h1 << p) | FIXED);
      chk("R7 oe", pin_oe, (32'h1 << p) | FIXED);
    end
    wr(A_DIR, 32'h0);
    rd(A_DIR, rv); chk("R8 clear ignored", rv, FIXED);

    // R6 R7 patterns
    wr(A_DIR, 32'hFF00_FF00);
    wr(A_OEN, 32'h0F0F_0F0F);
    rd(A_OEN, rv); chk("R6 oen pattern", rv, 32'h0F0F_0F0F);
    chk("R7 and", pin_oe, 32'h0F00_0F00 | (FIXED & 32'h0F0F_0F0F));
    wr(A_OEN, 32'h0);
    chk("R7 oen off", pin_oe, 32'h0);

    // R4 synchronizer latency
    for (int i = 0; i < 4; i++) begin
      logic [31:0] prev, nv;
      prev = pin_in;
      nv = 32'hDEAD_BEEF ^ (32'h1111_1111 * i);
      @(negedge clk); pin_in = nv;
      rd(A_VIEW, rv); chk("R4 one edge", rv, prev);
      rd(A_VIEW, rv); chk("R4 two edges", rv, nv);
    end

    // R10 write-only and unmapped reads, ignored writes
    rd(A_LO, rv); chk("R10 low port read", rv, 32'h0);
    rd(A_HI, rv); chk("R10 high port read", rv, 32'h0);
    rd(12'h100, rv); chk("R10 unmapped read", rv, 32'h0);
    wr(A_DIR, 32'h0000_00F0);
    wr(A_OEN, 32'h0000_0FF0);
    wr(A_VIEW, 32'h0000_0000);
    wr(12'h300, 32'hFFFF_FFFF);
    wr(12'h00C, 32'h0000_FFFF);
    chk("R10 pin_out kept", pin_out, exp_out);
    rd(A_DIR, rv); chk("R10 dir kept", rv, 32'h0000_01F0);
    rd(A_OEN, rv); chk("R10 oen kept", rv, 32'h0000_0FF0);

    // R9 reset again
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R9 pin_out after reset", pin_out, 32'h0);
    chk("R9 pin_oe after reset", pin_oe, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule